// File: doc/BRIEF.md
# SAR ADC Track-and-Convert Sequencer

This block is the timing controller for a 10-bit successive-approximation converter. It decides when the analog front end may track the input and when the SAR datapath may resolve bits. A 3-bit source field selects what starts a conversion. The choices are a software start pulse, one of four timer overflow strobes, or an external convert-start pin. The pin is asynchronous and is synchronized inside the block.

All timing is counted in SAR clocks. A SAR clock is an enable pulse made by dividing the system clock by `SAR_DIV`. The divider restarts when a conversion is accepted, so the latency from trigger to each SAR clock is fixed.

A tracking-mode input selects one of two policies:
- **Continuous tracking:** the input is tracked whenever no conversion runs.
- **Low-power tracking:** track/hold rests deasserted. Each internally started conversion first gets a timed window of 3 SAR clocks. With the pin as source, tracking follows the pin while it is low, and the rising edge starts conversion.

A shutdown input removes tracking entirely.

States:
- `ST_IDLE`: waits for a trigger.
- `ST_TRACK`: the timed low-power window.
- `ST_CONV`: 11 SAR clocks of bit resolution.
- `ST_DONE`: one cycle that raises the done strobe.

Transitions:
- `ST_IDLE` to `ST_TRACK`: an internal trigger in low-power mode.
- `ST_IDLE` to `ST_CONV`: any other trigger.
- `ST_TRACK` to `ST_CONV`: after the third SAR clock.
- `ST_CONV` to `ST_DONE`: after the eleventh SAR clock.
- `ST_DONE` to `ST_IDLE`: always, after one cycle.

Top module: `sar_conv_sched`

## Requirements
- R1: After reset, `busy`, `done` and `sar_step` are 0 and `sar_cnt` is 0.
- R2: With `lp_track`=0 and `shutdown`=0, `track_en` is 1 whenever the block is idle. It is 0 in every cycle of a conversion.
- R3: The trigger source is chosen by `trig_sel`:
  - 000: `sw_start`.
  - 001: `tmr_ovf[0]`.
  - 010: `tmr_ovf[2]`.
  - 011: `tmr_ovf[1]`.
  - 101: `tmr_ovf[3]`.
  - 100: the rising edge of `ext_start`.
  
  Strobes on sources that are not selected start nothing.
- R4: With `lp_track`=0, an internal trigger sampled at clock edge k makes `busy` 1 from edge k on. Conversion begins at once, and `busy` stays high for exactly 11·`SAR_DIV` cycles with no tracking cycles.
- R5: With `lp_track`=1 and an internal source, a conversion has two phases. First, `track_en` is 1 for 3·`SAR_DIV` cycles. Then 11·`SAR_DIV` convert cycles follow. `busy` is high for 14·`SAR_DIV` cycles in total.
- R6: With `lp_track`=1 and `trig_sel`=100, idle `track_en` equals the inverse of the pin delayed by two synchronizer flops. A pin rise driven before edge A gives `busy`=1 after edge A+2. No tracking window is added.
- R7: While `shutdown` is 1, `track_en` is 0 in every state. Conversion timing is unchanged.
- R8: The first cycle after the last convert clock has `done`=1 and `busy`=0. `done` lasts exactly one cycle.
- R9: Triggers arriving while `busy` is 1 are ignored. The conversion length is unchanged, and no second conversion follows.
- R10: `trig_sel` values 110 and 111 start no conversion, whatever the sources do.
- R11: `sar_step` pulses once per convert SAR clock, 11 times per conversion, and only while `busy` is 1. At the n-th pulse (n from 0), `sar_cnt` equals n, so the datapath resolves from the most significant bit downward.
- R12: With `lp_track`=1 and an internal source, idle `track_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Software start strobe (busy-bit write of 1) |
| tmr_ovf | input | 4 | Timer overflow strobes, bit n is timer n |
| ext_start | input | 1 | Asynchronous external convert-start pin |
| trig_sel | input | 3 | Trigger source select |
| lp_track | input | 1 | 1 = low-power timed tracking, 0 = continuous tracking |
| shutdown | input | 1 | Forces track/hold off (standby/sleep) |
| track_en | output | 1 | Track/hold enable to the sampling switch |
| sar_step | output | 1 | One-cycle enable per convert SAR clock |
| sar_cnt | output | $clog2(CONV_CLKS) | Index of the current convert SAR clock |
| busy | output | 1 | Conversion in progress (tracking window included) |
| done | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The assertions assume the following about the inputs:
- Trigger strobes are synchronous single-cycle pulses.
- `shutdown` changes only on clock edges.
- The default `SAR_DIV` of at least 2 is used.

Given these, `sar_step` and `track_en` never overlap, and `done` always follows a busy cycle. The directed stimulus drives every input at the falling clock edge. It holds `trig_sel` and `lp_track` constant for the whole of each conversion and changes them only while the block is idle. It keeps the external pin low before arming a pin-triggered run, so no reset-time edge is seen as a trigger.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        SRC_SW   = 3'b000,
        SRC_TMR0 = 3'b001,
        SRC_TMR2 = 3'b010,
        SRC_TMR1 = 3'b011,
        SRC_PIN  = 3'b100,
        SRC_TMR3 = 3'b101
    } trig_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRACK,
        ST_CONV,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int SAR_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (SAR_DIV <= 1) begin : g_pass
            assign tick = run;
        end else begin : g_div
            localparam int DW = $clog2(SAR_DIV);
            localparam logic [DW-1:0] LAST = DW'(SAR_DIV - 1);
            logic [DW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!run || cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/sar_trig_mux.sv
module sar_trig_mux
    import sar_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_start,
    input  logic [3:0] tmr_ovf,
    input  logic       ext_pin,
    input  logic [2:0] src_sel,
    output logic       trig,
    output logic       pin_lvl
);

    // chain[0..SYNC_STAGES-1] synchronize, chain[SYNC_STAGES] is edge history
    logic [SYNC_STAGES:0] chain;
    logic                 pin_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], ext_pin};
        end
    end

    assign pin_lvl  = chain[SYNC_STAGES-1];
    assign pin_rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    always_comb begin
        case (src_sel)
            SRC_SW:   trig = sw_start;
            SRC_TMR0: trig = tmr_ovf[0];
            SRC_TMR1: trig = tmr_ovf[1];
            SRC_TMR2: trig = tmr_ovf[2];
            SRC_TMR3: trig = tmr_ovf[3];
            SRC_PIN:  trig = pin_rise;
            default:  trig = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_conv_sched.sv
module sar_conv_sched
    import sar_seq_pkg::*;
#(
    parameter int SAR_DIV     = 4,
    parameter int TRACK_CLKS  = 3,
    parameter int CONV_CLKS   = 11,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(CONV_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_start,
    input  logic [3:0]       tmr_ovf,
    input  logic             ext_start,
    input  logic [2:0]       trig_sel,
    input  logic             lp_track,
    input  logic             shutdown,
    output logic             track_en,
    output logic             sar_step,
    output logic [CNT_W-1:0] sar_cnt,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] TRK_LAST = CNT_W'(TRACK_CLKS - 1);
    localparam logic [CNT_W-1:0] CNV_LAST = CNT_W'(CONV_CLKS - 1);

    seq_state_e       state, nxt;
    logic             trig, pin_lvl, tick, run;
    logic [CNT_W-1:0] ph;
    logic             pin_src;

    assign pin_src = (trig_sel == SRC_PIN);
    assign run     = (state == ST_TRACK) || (state == ST_CONV);

    sar_trig_mux #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_start (sw_start),
        .tmr_ovf  (tmr_ovf),
        .ext_pin  (ext_start),
        .src_sel  (trig_sel),
        .trig     (trig),
        .pin_lvl  (pin_lvl)
    );

    sar_tick_gen #(.SAR_DIV(SAR_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // SAR-clock phase counter, restarted on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (nxt != state) begin
            ph <= '0;
        end else if (tick) begin
            ph <= ph + 1'b1;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (trig) begin
                    nxt = (lp_track && !pin_src) ? ST_TRACK : ST_CONV;
                end
            end
            ST_TRACK: begin
                if (tick && ph == TRK_LAST) nxt = ST_CONV;
            end
            ST_CONV: begin
                if (tick && ph == CNV_LAST) nxt = ST_DONE;
            end
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        track_en = 1'b0;
        sar_step = 1'b0;
        sar_cnt  = '0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                track_en = !shutdown && (!lp_track || (pin_src && !pin_lvl));
            end
            ST_TRACK: begin
                busy     = 1'b1;
                track_en = !shutdown;
            end
            ST_CONV: begin
                busy     = 1'b1;
                sar_step = tick;
                sar_cnt  = ph;
            end
            ST_DONE: begin
                done     = 1'b1;
                track_en = !shutdown && !lp_track;
            end
        endcase
    end

endmodule

// File: rtl/sar_conv_sched_chk.sv
module sar_conv_sched_chk #(
    parameter int CONV_CLKS = 11,
    localparam int CNT_W    = $clog2(CONV_CLKS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shutdown,
    input logic             track_en,
    input logic             sar_step,
    input logic [CNT_W-1:0] sar_cnt,
    input logic             busy,
    input logic             done
);

    p_hold_in_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sar_step |-> !track_en);

    p_shutdown_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !track_en);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_step_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sar_step |-> (busy && sar_cnt < CNT_W'(CONV_CLKS)));

endmodule

bind sar_conv_sched sar_conv_sched_chk #(.CONV_CLKS(CONV_CLKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shutdown (shutdown),
    .track_en (track_en),
    .sar_step (sar_step),
    .sar_cnt  (sar_cnt),
    .busy     (busy),
    .done     (done)
);

// File: tb/sar_conv_sched_bench.sv
`timescale 1ns/1ps
module sar_conv_sched_bench;

    localparam int DIV   = 4;
    localparam int TRK   = 3;
    localparam int CNV   = 11;
    localparam int CNT_W = $clog2(CNV);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sw_start = 1'b0;
    logic [3:0]       tmr_ovf = '0;
    logic             ext_start = 1'b0;
    logic [2:0]       trig_sel = 3'b000;
    logic             lp_track = 1'b0;
    logic             shutdown = 1'b0;
    logic             track_en, sar_step, busy, done;
    logic [CNT_W-1:0] sar_cnt;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sar_conv_sched #(.SAR_DIV(DIV), .TRACK_CLKS(TRK), .CONV_CLKS(CNV)) u_sar_conv_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_start  (sw_start),
        .tmr_ovf   (tmr_ovf),
        .ext_start (ext_start),
        .trig_sel  (trig_sel),
        .lp_track  (lp_track),
        .shutdown  (shutdown),
        .track_en  (track_en),
        .sar_step  (sar_step),
        .sar_cnt   (sar_cnt),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fire(input logic [2:0] src);
        case (src)
            3'b000: sw_start   = 1'b1;
            3'b001: tmr_ovf[0] = 1'b1;
            3'b010: tmr_ovf[2] = 1'b1;
            3'b011: tmr_ovf[1] = 1'b1;
            3'b101: tmr_ovf[3] = 1'b1;
            default: ;
        endcase
    endtask

    task automatic clr_src();
        sw_start = 1'b0;
        tmr_ovf  = '0;
    endtask

    // called at the first negedge where busy must already be 1
    task automatic measure(input int exp_busy, input int exp_trk, input logic retrig, input string tag);
        int nb = 0;
        int nt = 0;
        int ns = 0;
        int bad_idx = 0;
        chk(busy == 1'b1, {tag, " busy at start (R4)"}, busy, 1);
        while (busy && nb < 2000) begin
            nb++;
            if (track_en) nt++;
            if (sar_step) begin
                if (sar_cnt != CNT_W'(ns)) bad_idx++;
                ns++;
            end
            if (retrig && nb == 10) begin
                sw_start = 1'b1;
                tmr_ovf  = '1;
            end
            @(negedge clk);
            clr_src();
        end
        chk(nb == exp_busy, {tag, " busy length"}, nb, exp_busy);
        chk(nt == exp_trk,  {tag, " tracking cycles"}, nt, exp_trk);
        chk(ns == CNV && bad_idx == 0, {tag, " sar_step count/index R11"}, ns, CNV);
        chk(done == 1'b1 && busy == 1'b0, {tag, " done after last clock R8"}, done, 1);
        @(negedge clk);
        chk(done == 1'b0, {tag, " done one cycle R8"}, done, 0);
    endtask

    task automatic run_internal(input logic [2:0] src, input logic lp, input logic retrig, input string tag);
        int eb;
        int et;
        trig_sel = src;
        lp_track = lp;
        @(negedge clk);
        fire(src);
        @(negedge clk);
        clr_src();
        eb = lp ? (TRK + CNV) * DIV : CNV * DIV;
        et = (lp && !shutdown) ? TRK * DIV : 0;
        measure(eb, et, retrig, tag);
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0 && sar_step == 0 && sar_cnt == 0, "R1 reset outputs", busy, 0);
        chk(track_en == 1'b1, "R2 idle tracking after reset", track_en, 1);
    endtask

    task automatic t_fast();
        run_internal(3'b000, 1'b0, 1'b0, "R4 software start fast");
        chk(track_en == 1'b1, "R2 tracking resumes in idle", track_en, 1);
    endtask

    task automatic t_timers();
        run_internal(3'b001, 1'b0, 1'b0, "R3 timer0");
        run_internal(3'b010, 1'b0, 1'b0, "R3 timer2");
        run_internal(3'b011, 1'b0, 1'b0, "R3 timer1");
        run_internal(3'b101, 1'b0, 1'b0, "R3 timer3");
    endtask

    task automatic t_wrong_src();
        int seen = 0;
        trig_sel = 3'b001;
        @(negedge clk);
        sw_start = 1'b1;
        tmr_ovf  = 4'b1110;
        ext_start = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            clr_src();
            if (busy) seen++;
        end
        ext_start = 1'b0;
        repeat (4) @(negedge clk);
        chk(seen == 0, "R3 unselected sources ignored", seen, 0);
    endtask

    task automatic t_bad_sel();
        int seen = 0;
        for (int s = 6; s < 8; s++) begin
            trig_sel = 3'(s);
            @(negedge clk);
            sw_start = 1'b1;
            tmr_ovf  = '1;
            ext_start = 1'b1;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                clr_src();
                if (busy) seen++;
            end
            ext_start = 1'b0;
            repeat (4) @(negedge clk);
        end
        chk(seen == 0, "R10 reserved select values", seen, 0);
    endtask

    task automatic t_lp_internal();
        trig_sel = 3'b010;
        lp_track = 1'b1;
        @(negedge clk);
        chk(track_en == 1'b0, "R12 low-power idle has track off", track_en, 1'b0);
        run_internal(3'b010, 1'b1, 1'b0, "R5 low-power timer2");
        chk(track_en == 1'b0, "R12 low-power idle after conversion", track_en, 1'b0);
        lp_track = 1'b0;
    endtask

    task automatic t_ext();
        trig_sel  = 3'b100;
        lp_track  = 1'b1;
        ext_start = 1'b0;
        repeat (4) @(negedge clk);
        chk(track_en == 1'b1, "R6 tracks while pin low", track_en, 1);
        ext_start = 1'b1;
        @(negedge clk);
        chk(track_en == 1'b1 && busy == 1'b0, "R6 one edge after rise", track_en, 1);
        @(negedge clk);
        chk(track_en == 1'b0 && busy == 1'b0, "R6 two edges after rise", track_en, 0);
        @(negedge clk);
        measure(CNV * DIV, 0, 1'b0, "R6 pin conversion");
        ext_start = 1'b0;
        repeat (4) @(negedge clk);
        chk(track_en == 1'b1 && busy == 1'b0, "R6 tracking returns with pin low", track_en, 1);
        lp_track = 1'b0;
    endtask

    task automatic t_retrig();
        int seen = 0;
        run_internal(3'b000, 1'b0, 1'b1, "R9 retrigger while busy");
        for (int i = 0; i < 6; i++) begin
            if (busy) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R9 no second conversion", seen, 0);
    endtask

    task automatic t_shutdown();
        shutdown = 1'b1;
        lp_track = 1'b0;
        trig_sel = 3'b000;
        @(negedge clk);
        chk(track_en == 1'b0, "R7 shutdown idle track off", track_en, 0);
        run_internal(3'b000, 1'b1, 1'b0, "R7 shutdown low-power conversion");
        lp_track = 1'b0;
        @(negedge clk);
        chk(track_en == 1'b0, "R7 shutdown still off", track_en, 0);
        shutdown = 1'b0;
        @(negedge clk);
        chk(track_en == 1'b1, "R2 tracking back after shutdown", track_en, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fast();
        t_timers();
        t_wrong_src();
        t_bad_sel();
        t_lp_internal();
        t_ext();
        t_retrig();
        t_shutdown();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule